// File: doc/BRIEF.md
# Priority-Level Interrupt Acceptance Controller

This block keeps the interrupt-related part of the processor status: a 4-bit current priority level, a global interrupt enable and a bus-hold enable bit. Every cycle it looks at a set of interrupt sources. Each source has a pending line, its own enable, a 4-bit level and a flag that marks it as a single-cycle transfer request. The block also sees a hardware trap line, a software trap strobe and a return strobe. From these it picks at most one event per cycle and updates the status.

When an ordinary interrupt is accepted, the status word is pushed onto a small internal stack and the level takes the level of the request. A transfer request is only acknowledged: it steals one cycle and leaves the level alone. A hardware trap saves the status and raises the level to the maximum. A software trap saves the status and keeps the level. A return pops the saved word back. Software can also write the three fields directly through a plain write port.

All pins are plain control and status signals. The acknowledge is a one-cycle pulse with no ready, because the request line stays pending until its owner sees the pulse. There is no back-pressure.

Top module: `prio_accept_ctrl`

## Requirements
- R1: After reset the level is 0, the global enable is 0, the hold enable is 0, the stack is empty, the error flag is 0 and no acknowledge is issued.
- R2: A source is eligible only when all four of these hold: its pending bit is 1, its enable is 1, the global enable is 1, and its level is strictly greater than the current level. A request at a level equal to or below the current level is never acknowledged.
- R3: Among eligible sources, the one with the highest level wins. On a tie, the lowest index wins. The block registers the choice and shows it one cycle later as `ack_valid`=1 for exactly one cycle, with `ack_idx` set to the winner's index.
- R4: When an ordinary (non-transfer) request wins, the current status word is pushed onto the stack, and at the same clock edge the level becomes the winner's level.
- R5: When a request with its transfer flag set wins, the block acknowledges it with `ack_xfer`=1. The level is unchanged and nothing is pushed.
- R6: A hardware trap pushes the status word and sets the level to 15 (4'hF). This happens whatever the global enable is. Because no source level can exceed 15, this blocks every request until the level is lowered again.
- R7: A software trap pushes the status word and leaves the level unchanged, whatever the global enable is. A higher-level request can then still be accepted on a later cycle.
- R8: While the global enable is 0, no interrupt or transfer request is acknowledged, even if its own enable is set.
- R9: A return strobe pops the most recently saved word and restores the level, the global enable and the hold enable from it.
- R10: A push when the stack already holds STK_DEPTH words (8 by default) discards the saved word. A pop from an empty stack changes nothing. Both set `stk_err`, which stays at 1 until reset.
- R11: A write strobe loads the level from `wr_lvl`, the global enable from `wr_gie` and the hold enable from `wr_hold`. The write takes effect only in a cycle with no trap, no return and no accepted request; otherwise it is lost.
- R12: When several events arrive in one cycle, they are served in this order: hardware trap, then software trap, then return, then request acceptance, then write. Only the first one takes effect, and no acknowledge is issued in a cycle taken by a trap or a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pend | input | NUM_SRC | Pending bit for each source |
| req_en | input | NUM_SRC | Individual enable for each source |
| req_lvl | input | NUM_SRC*4 | Level of each source; source i occupies bits [4i+3:4i] |
| req_xfer | input | NUM_SRC | Marks a source as a single-cycle transfer request |
| hw_trap | input | 1 | Hardware trap request |
| sw_trap | input | 1 | Software trap strobe |
| ret_strobe | input | 1 | Return from service: restore the saved status |
| wr_en | input | 1 | Direct write strobe for the status fields |
| wr_lvl | input | 4 | Level value to write |
| wr_gie | input | 1 | Global enable value to write |
| wr_hold | input | 1 | Hold enable value to write |
| ack_valid | output | 1 | One-cycle acknowledge pulse |
| ack_idx | output | $clog2(NUM_SRC) | Index of the acknowledged source |
| ack_xfer | output | 1 | Set when the acknowledge is for a transfer request |
| cur_lvl | output | 4 | Current priority level |
| gie | output | 1 | Global interrupt enable |
| hold_en | output | 1 | Bus-hold enable |
| stk_err | output | 1 | Sticky stack overflow or underflow flag |

## Verification
The bench targets the comparisons at the edges of the level rule.

- A request at exactly the current level must be refused. A design that compared with `>=` would acknowledge it again in the cycle after it was accepted.
- Ties at the same level must go to the lowest index. A design that resolved ties the other way would report the wrong `ack_idx`.
- A transfer must leave the level where it was. A design that moved the level on a transfer would lock out the very requests that should still come in.
- Traps must work with the global enable at 0. A hardware trap that did not force level 15 would show up as the wrong `cur_lvl`.
- A write or return in the same cycle as a higher-priority event must be lost. A design that let it through would leave the wrong fields after that cycle.
- The stack is pushed past eight entries and popped when empty. A design that wrapped its pointer would restore a stale word and never raise `stk_err`.

// File: rtl/prio_accept_pkg.sv
package prio_accept_pkg;
  localparam int unsigned LVL_W   = 4;
  localparam int unsigned STAT_W  = LVL_W + 2;

  typedef struct packed {
    logic             hold;
    logic             gie;
    logic [LVL_W-1:0] lvl;
  } stat_t;
endpackage

// File: rtl/prio_accept_arb.sv
module prio_accept_arb
  import prio_accept_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]       pend,
  input  logic [NUM_SRC-1:0]       en,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_vec,
  input  logic                     gie,
  input  logic [LVL_W-1:0]         cur_lvl,
  output logic                     win_vld,
  output logic [IDX_W-1:0]         win_idx,
  output logic [LVL_W-1:0]         win_lvl
);
  // Scanning upward with a strict compare keeps the lowest index on a tie.
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (gie && pend[i] && en[i] && (lvl_vec[i*LVL_W +: LVL_W] > cur_lvl) &&
          (!win_vld || (lvl_vec[i*LVL_W +: LVL_W] > win_lvl))) begin
        win_vld = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = lvl_vec[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/prio_accept_stack.sv
module prio_accept_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 6,
  localparam int unsigned PTR_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] cnt;

  assign full  = (cnt == PTR_W'(DEPTH));
  assign empty = (cnt == '0);
  assign top   = empty ? '0 : mem[cnt - 1'b1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (push && !full) begin
      cnt <= cnt + 1'b1;
    end else if (pop && !empty) begin
      cnt <= cnt - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= '0;
      end else if (push && !full && (cnt == PTR_W'(g))) begin
        mem[g] <= din;
      end
    end
  end
endmodule

// File: rtl/prio_accept_ctrl.sv
module prio_accept_ctrl
  import prio_accept_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 8,
  parameter int unsigned STK_DEPTH = 8,
  localparam int unsigned IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       req_pend,
  input  logic [NUM_SRC-1:0]       req_en,
  input  logic [NUM_SRC*LVL_W-1:0] req_lvl,
  input  logic [NUM_SRC-1:0]       req_xfer,
  input  logic                     hw_trap,
  input  logic                     sw_trap,
  input  logic                     ret_strobe,
  input  logic                     wr_en,
  input  logic [LVL_W-1:0]         wr_lvl,
  input  logic                     wr_gie,
  input  logic                     wr_hold,
  output logic                     ack_valid,
  output logic [IDX_W-1:0]         ack_idx,
  output logic                     ack_xfer,
  output logic [LVL_W-1:0]         cur_lvl,
  output logic                     gie,
  output logic                     hold_en,
  output logic                     stk_err
);
  stat_t            stat_q, stat_d;
  logic             win_vld;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] win_lvl;
  logic             push_req, push, pop, full, empty;
  logic [STAT_W-1:0] top_word;
  logic             ack_d, xfer_d, err_d;

  prio_accept_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .pend    (req_pend),
    .en      (req_en),
    .lvl_vec (req_lvl),
    .gie     (stat_q.gie),
    .cur_lvl (stat_q.lvl),
    .win_vld (win_vld),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  prio_accept_stack #(.DEPTH(STK_DEPTH), .W(STAT_W)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .din   (stat_q),
    .top   (top_word),
    .full  (full),
    .empty (empty)
  );

  // Event order: hardware trap, software trap, return, acceptance, write.
  always_comb begin
    stat_d   = stat_q;
    push_req = 1'b0;
    pop      = 1'b0;
    ack_d    = 1'b0;
    xfer_d   = 1'b0;
    err_d    = stk_err;
    if (hw_trap) begin
      push_req   = 1'b1;
      stat_d.lvl = '1;
    end else if (sw_trap) begin
      push_req = 1'b1;
    end else if (ret_strobe) begin
      if (empty) begin
        err_d = 1'b1;
      end else begin
        pop    = 1'b1;
        stat_d = stat_t'(top_word);
      end
    end else if (win_vld) begin
      ack_d = 1'b1;
      if (req_xfer[win_idx]) begin
        xfer_d = 1'b1;
      end else begin
        push_req   = 1'b1;
        stat_d.lvl = win_lvl;
      end
    end else if (wr_en) begin
      stat_d.lvl  = wr_lvl;
      stat_d.gie  = wr_gie;
      stat_d.hold = wr_hold;
    end
    push = push_req && !full;
    if (push_req && full) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q    <= '0;
      ack_valid <= 1'b0;
      ack_idx   <= '0;
      ack_xfer  <= 1'b0;
      stk_err   <= 1'b0;
    end else begin
      stat_q    <= stat_d;
      ack_valid <= ack_d;
      ack_idx   <= ack_d ? win_idx : '0;
      ack_xfer  <= xfer_d;
      stk_err   <= err_d;
    end
  end

  assign cur_lvl = stat_q.lvl;
  assign gie     = stat_q.gie;
  assign hold_en = stat_q.hold;
endmodule

// File: rtl/prio_accept_ctrl_chk.sv
module prio_accept_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hw_trap,
  input logic       sw_trap,
  input logic       ret_strobe,
  input logic       ack_valid,
  input logic       ack_xfer,
  input logic [3:0] cur_lvl,
  input logic       gie,
  input logic       stk_err
);
  assert_hw_trap_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_trap |=> (cur_lvl == 4'hF));

  assert_sw_trap_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_trap && !hw_trap) |=> $stable(cur_lvl));

  assert_ack_needs_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(gie));

  assert_no_ack_on_trap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> !$past(hw_trap || sw_trap || ret_strobe));

  assert_xfer_keeps_lvl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_xfer) |-> (cur_lvl == $past(cur_lvl)));

  assert_accept_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_xfer) |-> (cur_lvl > $past(cur_lvl)));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> stk_err);
endmodule

bind prio_accept_ctrl prio_accept_ctrl_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .hw_trap    (hw_trap),
  .sw_trap    (sw_trap),
  .ret_strobe (ret_strobe),
  .ack_valid  (ack_valid),
  .ack_xfer   (ack_xfer),
  .cur_lvl    (cur_lvl),
  .gie        (gie),
  .stk_err    (stk_err)
);

// File: tb/prio_accept_ctrl_tb_top.sv
module prio_accept_ctrl_tb_top;
  localparam int N = 8;
  localparam int D = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n;
  logic [N-1:0] req_pend, req_en, req_xfer;
  logic [N*4-1:0] req_lvl;
  logic         hw_trap, sw_trap, ret_strobe, wr_en, wr_gie, wr_hold;
  logic [3:0]   wr_lvl;
  logic         ack_valid, ack_xfer, gie, hold_en, stk_err;
  logic [2:0]   ack_idx;
  logic [3:0]   cur_lvl;

  prio_accept_ctrl #(.NUM_SRC(N), .STK_DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_pend(req_pend), .req_en(req_en),
    .req_lvl(req_lvl), .req_xfer(req_xfer), .hw_trap(hw_trap),
    .sw_trap(sw_trap), .ret_strobe(ret_strobe), .wr_en(wr_en),
    .wr_lvl(wr_lvl), .wr_gie(wr_gie), .wr_hold(wr_hold),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .ack_xfer(ack_xfer),
    .cur_lvl(cur_lvl), .gie(gie), .hold_en(hold_en), .stk_err(stk_err)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Reference state built from the requirements.
  logic [3:0] m_lvl;
  logic       m_gie, m_hold, m_err, m_ack, m_xfer;
  logic [2:0] m_idx;
  logic [5:0] m_stk [D];
  int         m_sp;

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic m_reset();
    m_lvl = 0; m_gie = 0; m_hold = 0; m_err = 0; m_ack = 0; m_xfer = 0;
    m_idx = 0; m_sp = 0;
  endtask

  task automatic m_push();
    if (m_sp == D) m_err = 1'b1;
    else begin m_stk[m_sp] = {m_hold, m_gie, m_lvl}; m_sp++; end
  endtask

  task automatic m_step();
    bit found = 0;
    int bi = 0;
    logic [3:0] bl = 0;
    for (int i = 0; i < N; i++) begin
      logic [3:0] lv = req_lvl[i*4 +: 4];
      if (m_gie && req_pend[i] && req_en[i] && lv > m_lvl && (!found || lv > bl)) begin
        found = 1; bi = i; bl = lv;
      end
    end
    m_ack = 0; m_xfer = 0; m_idx = 0;
    if (hw_trap) begin m_push(); m_lvl = 4'hF; end
    else if (sw_trap) m_push();
    else if (ret_strobe) begin
      if (m_sp == 0) m_err = 1'b1;
      else begin m_sp--; {m_hold, m_gie, m_lvl} = m_stk[m_sp]; end
    end else if (found) begin
      m_ack = 1; m_idx = 3'(bi);
      if (req_xfer[bi]) m_xfer = 1;
      else begin m_push(); m_lvl = bl; end
    end else if (wr_en) begin
      m_lvl = wr_lvl; m_gie = wr_gie; m_hold = wr_hold;
    end
  endtask

  task automatic clear_strobes();
    req_pend = 0; hw_trap = 0; sw_trap = 0; ret_strobe = 0; wr_en = 0;
  endtask

  // Inputs are driven at a falling edge; the result is compared one clock later.
  task automatic step(string tag);
    m_step();
    @(posedge clk);
    @(negedge clk);
    chk(tag, "ack_valid", ack_valid, m_ack);
    if (m_ack) begin
      chk(tag, "ack_idx", ack_idx, m_idx);
      chk(tag, "ack_xfer", ack_xfer, m_xfer);
    end
    chk(tag, "cur_lvl", cur_lvl, m_lvl);
    chk(tag, "gie", gie, m_gie);
    chk(tag, "hold_en", hold_en, m_hold);
    chk(tag, "stk_err", stk_err, m_err);
    clear_strobes();
  endtask

  task automatic set_src(int i, bit en, logic [3:0] lv, bit xf);
    req_en[i] = en; req_lvl[i*4 +: 4] = lv; req_xfer[i] = xf;
  endtask

  task automatic do_reset();
    rst_n = 0;
    clear_strobes();
    req_en = 0; req_lvl = 0; req_xfer = 0; wr_lvl = 0; wr_gie = 0; wr_hold = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_reset();
    @(negedge clk);
  endtask

  task automatic do_write(logic [3:0] l, bit g, bit h);
    wr_en = 1; wr_lvl = l; wr_gie = g; wr_hold = h;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    do_reset();
    // R1: reset state
    chk("R1", "cur_lvl", cur_lvl, 0);
    chk("R1", "gie", gie, 0);
    chk("R1", "hold_en", hold_en, 0);
    chk("R1", "stk_err", stk_err, 0);
    chk("R1", "ack_valid", ack_valid, 0);

    set_src(0, 1, 4'd5, 0); req_pend = 8'h01; step("R8");
    do_write(4'd3, 1, 1); step("R11");
    set_src(1, 1, 4'd3, 0); set_src(2, 0, 4'd9, 0); set_src(3, 1, 4'd2, 0);
    req_pend = 8'b0000_1110; step("R2");
    set_src(4, 1, 4'd7, 0); set_src(5, 1, 4'd7, 0); set_src(6, 1, 4'd6, 0);
    req_pend = 8'b0111_0000; step("R3");
    req_pend = 8'b0001_0000; step("R2");
    set_src(7, 1, 4'd9, 1); req_pend = 8'h80; step("R5");
    sw_trap = 1; req_pend = 8'h80; step("R7");
    set_src(0, 1, 4'd8, 0); req_pend = 8'h01; step("R7");
    set_src(5, 1, 4'd9, 0); req_pend = 8'h20; step("R4");
    ret_strobe = 1; step("R9");
    ret_strobe = 1; step("R9");
    ret_strobe = 1; step("R9");
    ret_strobe = 1; step("R9");
    do_write(4'd2, 0, 0); step("R11");
    hw_trap = 1; do_write(4'd1, 1, 1); step("R6");
    set_src(0, 1, 4'd15, 0); req_pend = 8'h01; step("R6");
    ret_strobe = 1; step("R9");
    do_write(4'd2, 1, 0); step("R11");
    set_src(0, 1, 4'd9, 0); req_pend = 8'h01; do_write(4'd5, 1, 1); step("R12");
    ret_strobe = 1; req_pend = 8'h01; step("R12");
    sw_trap = 1; hw_trap = 1; step("R12");
    for (int k = 0; k < 4; k++) begin ret_strobe = 1; step("R10"); end
    for (int k = 0; k < D + 2; k++) begin sw_trap = 1; step("R10"); end

    do_reset();
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 15) == 0) begin
        int s = $urandom_range(0, N - 1);
        set_src(s, $urandom_range(0, 3) != 0, 4'($urandom), $urandom_range(0, 3) == 0);
      end
      req_pend   = 8'($urandom & $urandom & $urandom);
      hw_trap    = ($urandom_range(0, 63) == 0);
      sw_trap    = ($urandom_range(0, 31) == 0);
      ret_strobe = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 9) == 0)
        do_write(4'($urandom_range(0, 10)), $urandom_range(0, 7) != 0, 1'($urandom));
      step("R12");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule